// File: doc/BRIEF.md
# Processor Debug Mode Controller

This block decides when a processor core is frozen in debug mode and how it behaves while frozen. It keeps a cause register, in which each bit records that a particular exception event was recognized, and an enable register, which selects the causes that force debug entry. When any recorded cause is also enabled, the block raises a one-cycle save strobe so that the core's return-address and status registers are captured. In the next cycle it asserts freeze and steers instruction fetches to the debug port.

While frozen, exceptions are recorded and reported but never processed. A recognized event sets its cause bit and produces a one-cycle report pulse. The fetch in the cycle of the event is held back, so the report always comes before the next fetch is issued. Breakpoint and watchpoint events are suppressed in debug mode. External and decrementer events are masked because the interrupt-enable flag is cleared on entry, and writes to that flag are refused while frozen. A return-from-interrupt strobe leaves debug mode. If an enabled cause has not been cleared, the block re-enters debug mode at once. Software clears causes through the register port, either by reading the cause register or by writing ones to it.

Top module: `dbgmode_ctrl`

## Requirements
- R1: While `freeze_o` is high, `fetch_sel_o` is high so that fetches are routed to the debug port. `fetch_go_o` is high only when `fetch_req_i` is high.
- R2: In debug mode, an event recognized in cycle t sets its cause bit and drives `report_o` high in cycle t+1 only, provided no further event is recognized.
- R3: In debug mode, `fetch_go_o` is low in any cycle with a recognized event, so the report pulse comes before the next issued fetch.
- R4: `save_o` is high only in the single cycle before `freeze_o` rises. It is never high while frozen, and events recognized in debug mode never raise it.
- R5: Cause bit 2 (breakpoint) and cause bit 3 (watchpoint) are recorded in normal mode and never recorded in debug mode.
- R6: Cause bit 0 (external) and cause bit 1 (decrementer) are recorded only while `ee_o` is high. Debug entry clears `ee_o`, and `ee_wr_i` is ignored while frozen. All other cause bits are recorded whenever their event strobe is high.
- R7: `rfi_i` high while frozen makes `freeze_o` low in the next cycle.
- R8: When not frozen and any cause bit is set with its enable bit set, `save_o` is high in that cycle and `freeze_o` is high in the next. This includes the cycle right after an exit whose cause was not cleared.
- R9: An external event held high with `ee_o` set is recognized again in every cycle, so its cause bit cannot be cleared while the level persists.
- R10: With `reg_sel_i`=0, `reg_rdata_o` shows the cause register. A read (`reg_rd_i`) clears all cause bits, and a write clears the bits written as one. An event in the same cycle as a clear takes priority. With `reg_sel_i`=1, the port reads the enable register and writes replace it.
- R11: Reset clears the cause and enable registers and `ee_o`, and drives `freeze_o`, `report_o` and `save_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | NCAUSE | Per-cycle exception event strobes, one per cause bit |
| rfi_i | input | 1 | Return-from-interrupt strobe |
| fetch_req_i | input | 1 | Core requests an instruction fetch |
| ee_wr_i | input | 1 | Write strobe for the interrupt-enable flag |
| ee_wdata_i | input | 1 | Value for the interrupt-enable flag |
| reg_sel_i | input | 1 | Register select: 0 cause, 1 enable |
| reg_rd_i | input | 1 | Register read strobe |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | NCAUSE | Register write data |
| reg_rdata_o | output | NCAUSE | Register read data |
| freeze_o | output | 1 | Core is frozen in debug mode |
| fetch_sel_o | output | 1 | Fetch source select: high routes fetches to the debug port |
| fetch_go_o | output | 1 | Fetch may be issued this cycle |
| report_o | output | 1 | One-cycle exception report pulse |
| save_o | output | 1 | Capture return-address and status registers |
| ee_o | output | 1 | Interrupt-enable flag |

## Verification
The bench builds the block with NCAUSE=6. This gives the four special cause bits plus two generic ones, so every cause bit can be pulsed in both modes and with the interrupt-enable flag at both values. The expected cause contents and report pulses are computed from the bit index, the mode and the flag. The small width keeps the full cross of bit, mode and flag short, while entry, exit, re-entry, the held external level and the set-over-clear priority are each driven at their exact cycles.

// File: rtl/dbg_pkg.sv
package dbg_pkg;
  localparam int unsigned CAUSE_EXT = 0;
  localparam int unsigned CAUSE_DEC = 1;
  localparam int unsigned CAUSE_BRK = 2;
  localparam int unsigned CAUSE_WCH = 3;
  localparam int unsigned CAUSE_MIN = 4;

  typedef enum logic {
    SEL_CAUSE  = 1'b0,
    SEL_ENABLE = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/dbg_event_qual.sv
module dbg_event_qual #(
  parameter int unsigned N = 8
) (
  input  logic [N-1:0] evt,
  input  logic         in_dbg,
  input  logic         ee,
  output logic [N-1:0] qual
);
  import dbg_pkg::*;

  for (genvar g = 0; g < N; g++) begin : g_bit
    if (g == CAUSE_EXT || g == CAUSE_DEC) begin : g_masked
      assign qual[g] = evt[g] & ee;
    end else if (g == CAUSE_BRK || g == CAUSE_WCH) begin : g_trap
      assign qual[g] = evt[g] & ~in_dbg;
    end else begin : g_plain
      assign qual[g] = evt[g];
    end
  end
endmodule

// File: rtl/dbg_cause_regs.sv
module dbg_cause_regs #(
  parameter int unsigned N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] qual,
  input  logic         sel,
  input  logic         rd,
  input  logic         wr,
  input  logic [N-1:0] wdata,
  output logic [N-1:0] rdata,
  output logic [N-1:0] cause,
  output logic [N-1:0] enable
);
  import dbg_pkg::*;

  function automatic logic [N-1:0] clear_mask(input logic to_cause, input logic do_rd,
                                              input logic do_wr, input logic [N-1:0] wd);
    logic [N-1:0] m;
    m = '0;
    if (to_cause) begin
      if (do_rd) m = '1;
      if (do_wr) m = m | wd;
    end
    return m;
  endfunction

  reg_sel_e     sel_e;
  logic [N-1:0] clr;

  assign sel_e = reg_sel_e'(sel);
  assign clr   = clear_mask(sel_e == SEL_CAUSE, rd, wr, wdata);
  assign rdata = (sel_e == SEL_ENABLE) ? enable : cause;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cause  <= '0;
      enable <= '0;
    end else begin
      cause <= (cause & ~clr) | qual;
      if (wr && sel_e == SEL_ENABLE) enable <= wdata;
    end
  end
endmodule

// File: rtl/dbg_mode_fsm.sv
module dbg_mode_fsm (
  input  logic clk,
  input  logic rst_n,
  input  logic pending,
  input  logic rfi,
  input  logic rec_any,
  input  logic ee_wr,
  input  logic ee_wdata,
  input  logic fetch_req,
  output logic in_dbg,
  output logic ee,
  output logic report,
  output logic save,
  output logic fetch_go
);
  logic enter;
  logic leave;
  logic hold_fetch;

  assign enter      = ~in_dbg & pending;
  assign leave      = in_dbg & rfi;
  assign hold_fetch = in_dbg & rec_any;
  assign save       = enter;
  assign fetch_go   = fetch_req & ~hold_fetch;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_dbg <= 1'b0;
      ee     <= 1'b0;
      report <= 1'b0;
    end else begin
      if (enter)      in_dbg <= 1'b1;
      else if (leave) in_dbg <= 1'b0;

      if (enter)                ee <= 1'b0;
      else if (ee_wr && !in_dbg) ee <= ee_wdata;

      report <= hold_fetch;
    end
  end
endmodule

// File: rtl/dbgmode_ctrl.sv
module dbgmode_ctrl #(
  parameter int unsigned NCAUSE = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCAUSE-1:0] evt_i,
  input  logic              rfi_i,
  input  logic              fetch_req_i,
  input  logic              ee_wr_i,
  input  logic              ee_wdata_i,
  input  logic              reg_sel_i,
  input  logic              reg_rd_i,
  input  logic              reg_wr_i,
  input  logic [NCAUSE-1:0] reg_wdata_i,
  output logic [NCAUSE-1:0] reg_rdata_o,
  output logic              freeze_o,
  output logic              fetch_sel_o,
  output logic              fetch_go_o,
  output logic              report_o,
  output logic              save_o,
  output logic              ee_o
);
  logic [NCAUSE-1:0] qual_w;
  logic [NCAUSE-1:0] cause_w;
  logic [NCAUSE-1:0] enable_w;
  logic              pending_w;
  logic              rec_any_w;
  logic              dbg_w;

  assign pending_w   = |(cause_w & enable_w);
  assign rec_any_w   = |qual_w;
  assign freeze_o    = dbg_w;
  assign fetch_sel_o = dbg_w;

  dbg_event_qual #(.N(NCAUSE)) qual_i (
    .evt    (evt_i),
    .in_dbg (dbg_w),
    .ee     (ee_o),
    .qual   (qual_w)
  );

  dbg_cause_regs #(.N(NCAUSE)) regs_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .qual   (qual_w),
    .sel    (reg_sel_i),
    .rd     (reg_rd_i),
    .wr     (reg_wr_i),
    .wdata  (reg_wdata_i),
    .rdata  (reg_rdata_o),
    .cause  (cause_w),
    .enable (enable_w)
  );

  dbg_mode_fsm fsm_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .pending   (pending_w),
    .rfi       (rfi_i),
    .rec_any   (rec_any_w),
    .ee_wr     (ee_wr_i),
    .ee_wdata  (ee_wdata_i),
    .fetch_req (fetch_req_i),
    .in_dbg    (dbg_w),
    .ee        (ee_o),
    .report    (report_o),
    .save      (save_o),
    .fetch_go  (fetch_go_o)
  );
endmodule

// File: rtl/dbgmode_ctrl_chk.sv
module dbgmode_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       freeze_o,
  input logic       rfi_i,
  input logic       fetch_req_i,
  input logic       fetch_go_o,
  input logic       report_o,
  input logic       save_o,
  input logic       ee_o,
  input logic [3:0] qual,
  input logic       pending,
  input logic       rec_any
);
  p_fetch_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_go_o |-> fetch_req_i);

  p_fetch_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze_o && rec_any) |-> !fetch_go_o);

  p_report_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze_o && rec_any) |=> report_o);

  p_report_src_r2: assert property (@(posedge clk) disable iff (!rst_n)
    report_o |-> $past(freeze_o && rec_any));

  p_save_normal_r4: assert property (@(posedge clk) disable iff (!rst_n)
    save_o |-> !freeze_o);

  p_save_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
    save_o |=> freeze_o);

  p_no_trap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    freeze_o |-> (!qual[2] && !qual[3]));

  p_ee_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(freeze_o) |-> !ee_o);

  p_ee_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
    freeze_o |-> (!qual[0] && !qual[1]));

  p_exit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze_o && rfi_i) |=> !freeze_o);

  p_entry_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!freeze_o && pending) |=> freeze_o);
endmodule

bind dbgmode_ctrl dbgmode_ctrl_chk chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .freeze_o    (freeze_o),
  .rfi_i       (rfi_i),
  .fetch_req_i (fetch_req_i),
  .fetch_go_o  (fetch_go_o),
  .report_o    (report_o),
  .save_o      (save_o),
  .ee_o        (ee_o),
  .qual        (qual_w[3:0]),
  .pending     (pending_w),
  .rec_any     (rec_any_w)
);

// File: tb/dbgmode_ctrl_tb_top.sv
module dbgmode_ctrl_tb_top;
  localparam int unsigned N = 6;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [N-1:0] evt_i;
  logic         rfi_i, fetch_req_i, ee_wr_i, ee_wdata_i;
  logic         reg_sel_i, reg_rd_i, reg_wr_i;
  logic [N-1:0] reg_wdata_i;
  logic [N-1:0] reg_rdata_o;
  logic         freeze_o, fetch_sel_o, fetch_go_o, report_o, save_o, ee_o;

  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  dbgmode_ctrl #(.NCAUSE(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .rfi_i(rfi_i),
    .fetch_req_i(fetch_req_i), .ee_wr_i(ee_wr_i), .ee_wdata_i(ee_wdata_i),
    .reg_sel_i(reg_sel_i), .reg_rd_i(reg_rd_i), .reg_wr_i(reg_wr_i),
    .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o),
    .freeze_o(freeze_o), .fetch_sel_o(fetch_sel_o), .fetch_go_o(fetch_go_o),
    .report_o(report_o), .save_o(save_o), .ee_o(ee_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #2;
  endtask

  // read the cause (sel 0) or enable (sel 1) register; returns the value seen
  task automatic rd_reg(input logic sel, output logic [N-1:0] val);
    reg_sel_i = sel;
    reg_rd_i  = 1'b1;
    #1 val = reg_rdata_o;
    cyc();
    reg_rd_i = 1'b0;
  endtask

  task automatic wr_reg(input logic sel, input logic [N-1:0] d);
    reg_sel_i   = sel;
    reg_wr_i    = 1'b1;
    reg_wdata_i = d;
    cyc();
    reg_wr_i    = 1'b0;
    reg_wdata_i = '0;
  endtask

  task automatic set_ee(input logic v);
    ee_wr_i    = 1'b1;
    ee_wdata_i = v;
    cyc();
    ee_wr_i    = 1'b0;
  endtask

  task automatic pulse(input int unsigned idx);
    evt_i = N'(1) << idx;
    cyc();
    evt_i = '0;
  endtask

  // expected recording of event idx given mode and interrupt-enable flag
  function automatic logic recorded(input int unsigned idx, input logic dbg, input logic ee);
    if (idx < 2) return ee;
    if (idx < 4) return !dbg;
    return 1'b1;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [N-1:0] v;
    rst_n = 1'b0; evt_i = '0; rfi_i = 0; fetch_req_i = 0; ee_wr_i = 0; ee_wdata_i = 0;
    reg_sel_i = 0; reg_rd_i = 0; reg_wr_i = 0; reg_wdata_i = '0;
    cyc(); cyc();
    rst_n = 1'b1;
    #1;
    // R11 reset state
    chk("R11 freeze", 32'(freeze_o), 0);
    chk("R11 report", 32'(report_o), 0);
    chk("R11 save", 32'(save_o), 0);
    chk("R11 ee", 32'(ee_o), 0);
    chk("R11 cause", 32'(reg_rdata_o), 0);
    reg_sel_i = 1; #1;
    chk("R11 enable", 32'(reg_rdata_o), 0);
    reg_sel_i = 0;

    // normal-mode sweep: every bit, both flag values (R5, R6, R10)
    for (int e = 0; e < 2; e++) begin
      set_ee(e[0]);
      chk("R6 ee write normal", 32'(ee_o), 32'(e));
      for (int i = 0; i < N; i++) begin
        pulse(i);
        chk("R2 no report normal", 32'(report_o), 0);
        rd_reg(0, v);
        chk($sformatf("R5 R6 normal record bit%0d ee%0d", i, e), 32'(v),
            recorded(i, 1'b0, e[0]) ? (32'd1 << i) : 0);
        #1 chk("R10 read clears", 32'(reg_rdata_o), 0);
      end
    end

    // R9 held external level with ee=1; R10 set beats clear
    evt_i = 1;
    cyc();
    rd_reg(0, v);
    chk("R9 level seen", 32'(v), 1);
    rd_reg(0, v);
    chk("R9 R10 re-recognized over read clear", 32'(v), 1);
    wr_reg(0, 1);
    #1 chk("R9 R10 re-recognized over w1c", 32'(reg_rdata_o), 1);
    evt_i = 0;
    cyc();
    wr_reg(0, 1);
    #1 chk("R10 w1c clears after level drops", 32'(reg_rdata_o), 0);

    // enable register write/readback (R10), read does not clear it
    wr_reg(1, 6'b100000);
    rd_reg(1, v);
    chk("R10 enable readback", 32'(v), 32'h20);
    rd_reg(1, v);
    chk("R10 enable kept after read", 32'(v), 32'h20);

    // entry (R8, R4, R6, R1) with ee still 1
    chk("R6 ee before entry", 32'(ee_o), 1);
    pulse(5);
    chk("R8 R4 save before freeze", 32'(save_o), 1);
    chk("R8 freeze not yet", 32'(freeze_o), 0);
    cyc();
    chk("R8 freeze after entry", 32'(freeze_o), 1);
    chk("R1 fetch select", 32'(fetch_sel_o), 1);
    chk("R4 save low in debug", 32'(save_o), 0);
    chk("R6 ee cleared on entry", 32'(ee_o), 0);
    wr_reg(0, '1);

    // debug sweep (R2, R3, R5, R6, R4)
    for (int i = 0; i < N; i++) begin
      logic r;
      r = recorded(i, 1'b1, 1'b0);
      evt_i = N'(1) << i;
      fetch_req_i = 1'b1;
      #1 chk($sformatf("R3 fetch hold bit%0d", i), 32'(fetch_go_o), 32'(!r));
      cyc();
      evt_i = '0;
      #1 chk($sformatf("R2 report bit%0d", i), 32'(report_o), 32'(r));
      chk("R1 fetch passes without event", 32'(fetch_go_o), 1);
      chk("R4 no save in debug", 32'(save_o), 0);
      fetch_req_i = 1'b0;
      #1 chk("R1 no fetch without request", 32'(fetch_go_o), 0);
      cyc();
      chk("R2 report one cycle", 32'(report_o), 0);
      rd_reg(0, v);
      chk($sformatf("R2 R5 R6 debug record bit%0d", i), 32'(v), r ? (32'd1 << i) : 0);
    end

    // R6 flag writes refused in debug
    set_ee(1'b1);
    chk("R6 ee write ignored in debug", 32'(ee_o), 0);

    // clean exit (R7)
    rfi_i = 1;
    cyc();
    rfi_i = 0;
    chk("R7 freeze drops", 32'(freeze_o), 0);
    chk("R7 fetch select drops", 32'(fetch_sel_o), 0);
    chk("R8 no save on clean exit", 32'(save_o), 0);
    cyc();
    chk("R7 stays out", 32'(freeze_o), 0);

    // exit with uncleared enabled cause -> re-entry (R8)
    pulse(5);
    cyc();
    chk("R8 second entry", 32'(freeze_o), 1);
    rfi_i = 1;
    cyc();
    rfi_i = 0;
    chk("R7 exit before re-entry", 32'(freeze_o), 0);
    chk("R8 R4 save on re-entry", 32'(save_o), 1);
    cyc();
    chk("R8 re-entered", 32'(freeze_o), 1);
    wr_reg(0, '1);
    rfi_i = 1;
    cyc();
    rfi_i = 0;
    cyc();
    chk("R8 no re-entry after clear", 32'(freeze_o), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule